// File: doc/BRIEF.md
# Elastic Stall-Propagating Two-Phase Pipeline

This block is a chain of an even number of data stages arranged like a two-phase latch pipeline. It uses a single clock and a phase flag that alternates every cycle. Odd-numbered stages load on one value of the flag and even-numbered stages load on the other. In free flow, one item moves one stage per cycle. Only half of the stages carry live items at any time, so the other half act as spare slots.

A stall request from the consumer does not reach every stage at once. Each stage owns a stall register that copies the stall register of its downstream neighbour. That register updates only on the phase in which its own stage does not load. The stall therefore walks backward one stage per cycle. While it walks, the spare slots fill, so no item is overwritten. When the stall is released, stages resume one at a time from the output end and the spare slots reappear.

The producer sees the stall that has reached stage 1 as `in_stall`. It must keep `in_data` steady until the item is taken. The consumer reads `phase` to know when its stall input is sampled and when `out_data` is handed over. No per-item valid flag exists. The reset contents of the stages therefore leave the output as ordinary zero items ahead of the first real item.

Top module: `elastic_pipe`

## Requirements
- R1: While `rst` is high at a clock edge, every stage and stall register clears to zero. After reset, `phase` is 0, `in_stall` is 0 and `out_data` is 0.
- R2: `phase` inverts on every clock edge after reset. Odd-numbered stages (1, 3, ...) load only at edges where `phase` is 1. Even-numbered stages load only at edges where `phase` is 0. Stage 1 is at the input and stage N is at the output.
- R3: With `out_stall` held low, an item taken at input edge e is handed out at edge e+N. The first N/2 items handed out after reset have the value 0.
- R4: A stage whose stall bit is set keeps its contents. While `out_stall` is held high, `out_data` does not change once the stall has reached stage N.
- R5: The stall moves backward one stage per cycle. Each stall register updates only at edges opposite to its own stage's load phase, and it is never held. After an edge where `phase` was 0, `in_stall` equals the value `out_stall` had at the edge N-1 cycles earlier. After an edge where `phase` was 1, `in_stall` keeps its value.
- R6: `in_data` is accepted only at an edge where `phase` is 1 and `in_stall` is 0, so at most one item enters every other cycle. At any other edge the producer holds the same item.
- R7: If `out_stall` stays high long enough, the pipeline holds exactly N distinct items and accepts no more. When the stall is released and stays low, occupancy settles back to N/2.
- R8: The item handed out at an edge where `phase` is 1 and `out_stall` is 0 is always the oldest item not yet handed out. This holds under any stall pattern, with no loss and no duplicate.
- R9: `out_stall` is sampled only at edges where `phase` is 1. Its value at edges where `phase` is 0 has no effect on `in_stall` or on the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | WIDTH | Item presented by the producer, held until accepted |
| in_stall | output | 1 | Stall register of stage 1; the producer must not advance while high |
| out_data | output | WIDTH | Contents of stage N |
| out_stall | input | 1 | Consumer stall request, sampled at edges where `phase` is 1 |
| phase | output | 1 | Current phase flag; 1 selects odd-stage loading |

## Verification
Free flow with `out_stall` low fixes the latency and the leading reset items. A stall driven high only on phase-0 cycles must leave the stream and `in_stall` untouched, which separates correct sampling from sampling on every edge. A long stall must fill all N stages and freeze the output, which shows that the spare slots absorb the backward walk. After it, and after a long run of random stalls, every handed-out item is compared with a behavioural queue and `in_stall` is compared with a delayed copy of `out_stall`. Together these expose loss, duplication and an off-by-one walk.

// File: rtl/elastic_pipe_pkg.sv
package elastic_pipe_pkg;

  // Load phase of a stage: odd stages load when the flag is 1.
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  function automatic phase_e phase_of_stage(input int unsigned idx);
    return (idx % 2 == 1) ? PH_ODD : PH_EVEN;
  endfunction

endpackage

// File: rtl/elastic_pipe_phase.sv
module elastic_pipe_phase
  import elastic_pipe_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);

  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_EVEN;
    else     ph_q <= (ph_q == PH_ODD) ? PH_EVEN : PH_ODD;
  end

  assign phase = ph_q;

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ph_q != $past(ph_q))); // R2

endmodule

// File: rtl/elastic_pipe_stage.sv
module elastic_pipe_stage
  import elastic_pipe_pkg::*;
#(
  parameter int     WIDTH      = 16,
  parameter phase_e LOAD_PHASE = PH_ODD
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase,
  input  logic [WIDTH-1:0] d_in,
  input  logic             stall_in,
  output logic [WIDTH-1:0] d_out,
  output logic             stall_out
);

  logic [WIDTH-1:0] data_q;
  logic             stall_q;
  logic             active;

  // Own load phase for data; the stall register uses the other phase.
  assign active = (phase == LOAD_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      if (active && !stall_q) data_q <= d_in;
      if (!active)            stall_q <= stall_in;
    end
  end

  assign d_out     = data_q;
  assign stall_out = stall_q;

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (active && stall_q) |=> $stable(data_q)); // R4

  AST_OFF_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(data_q)); // R2

  AST_STALL_OFF_PHASE: assert property (@(posedge clk) disable iff (rst)
    active |=> $stable(stall_q)); // R5

endmodule

// File: rtl/elastic_pipe.sv
module elastic_pipe
  import elastic_pipe_pkg::*;
#(
  parameter int STAGES = 8,
  parameter int WIDTH  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_stall,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_stall,
  output logic             phase
);

  localparam int LAST = STAGES;
  localparam int TAIL = STAGES + 1;

  phase_e           ph;
  logic [WIDTH-1:0] dat [0:LAST];
  logic             stl [1:TAIL];

  elastic_pipe_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (ph)
  );

  assign dat[0]    = in_data;
  assign stl[TAIL] = out_stall;

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    localparam phase_e LP = phase_of_stage(i);
    elastic_pipe_stage #(
      .WIDTH      (WIDTH),
      .LOAD_PHASE (LP)
    ) u_stage (
      .clk       (clk),
      .rst       (rst),
      .phase     (ph),
      .d_in      (dat[i-1]),
      .stall_in  (stl[i+1]),
      .d_out     (dat[i]),
      .stall_out (stl[i])
    );
  end

  assign in_stall = stl[1];
  assign out_data = dat[LAST];
  assign phase    = (ph == PH_ODD);

  // Stall at the input end only rises after the second stage was stalled.
  AST_STALL_FROM_NEIGHBOUR: assert property (@(posedge clk) disable iff (rst)
    $rose(in_stall) |-> $past(stl[2])); // R5

  // A producer-side stall blocks loading of stage 1.
  AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (in_stall && phase) |=> $stable(dat[1])); // R6

endmodule

// File: tb/test_elastic_pipe.sv
`timescale 1ns/1ps
module test_elastic_pipe;
  localparam int N = 8;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_data = '0;
  logic         in_stall;
  logic [W-1:0] out_data;
  logic         out_stall = 1'b0;
  logic         phase;

  always #4 clk = ~clk;

  elastic_pipe #(.STAGES(N), .WIDTH(W)) i_elastic_pipe (
    .clk(clk), .rst(rst), .in_data(in_data), .in_stall(in_stall),
    .out_data(out_data), .out_stall(out_stall), .phase(phase)
  );

  int checks = 0;
  int errors = 0;
  int item_q[$];
  int when_q[$];
  int hist[$];
  int next_item = 1;
  int edge_no = 0;
  int takes = 0;
  bit exp_ist = 1'b0;
  bit lat_on = 1'b0;
  bit prev_ph = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 free, 1 stall, 2 random, 3 stall only on phase-0 cycles
  task automatic step(input int mode);
    bit os;
    int expv;
    int w;
    @(negedge clk);
    check(in_stall == exp_ist, "R5 in_stall", in_stall, exp_ist);
    if (edge_no > 0) check(phase != prev_ph, "R2 phase toggle", phase, !prev_ph);
    prev_ph = phase;
    case (mode)
      0: os = 1'b0;
      1: os = 1'b1;
      2: os = ($urandom_range(0, 99) < 45);
      default: os = !phase;
    endcase
    out_stall = os;
    in_data = next_item[W-1:0];
    hist.push_back(int'(os));
    if (phase && !in_stall) begin
      item_q.push_back(next_item);
      when_q.push_back(edge_no);
      next_item++;
    end
    if (phase && !os) begin
      takes++;
      if (item_q.size() == 0) begin
        check(1'b0, "R8 underflow", out_data, -1);
      end else begin
        expv = item_q.pop_front();
        w = when_q.pop_front();
        check(out_data == expv[W-1:0], "R6,R8 order", out_data, expv);
        if (lat_on && w >= 0) check(edge_no - w == N, "R3 latency", edge_no - w, N);
      end
    end
    if (!phase) exp_ist = (edge_no >= N-1) ? (hist[edge_no-(N-1)] != 0) : 1'b0;
    edge_no++;
  endtask

  initial begin
    int t0;
    logic [W-1:0] held;
    for (int k = 0; k < N/2; k++) begin
      item_q.push_back(0);   // R3: reset contents leave as zero items
      when_q.push_back(-1);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_stall == 1'b0, "R1 in_stall", in_stall, 0);
    check(out_data == '0, "R1 out_data", out_data, 0);
    check(phase == 1'b0, "R1 phase", phase, 0);
    rst = 1'b0;

    lat_on = 1'b1;
    for (int k = 0; k < 60; k++) step(0);
    lat_on = 1'b0;

    t0 = takes;
    for (int k = 0; k < 40; k++) step(3);
    check(takes - t0 == 20, "R9 takes with phase-0 stall", takes - t0, 20);
    check(in_stall == 1'b0, "R9 in_stall", in_stall, 0);

    held = '0;
    for (int k = 1; k <= 4*N; k++) begin
      step(1);
      if (k == 3) held = out_data;
      if (k > 3) check(out_data == held, "R4 out_data hold", out_data, held);
    end
    check(item_q.size() == N, "R7 full occupancy", item_q.size(), N);
    check(in_stall == 1'b1, "R7 in_stall full", in_stall, 1);

    for (int k = 0; k < 3*N; k++) step(0);
    check(item_q.size() == N/2, "R7 occupancy after release", item_q.size(), N/2);

    for (int k = 0; k < 3000; k++) step(2);
    for (int k = 0; k < 4*N; k++) step(0);
    check(item_q.size() == N/2, "R8 occupancy after random", item_q.size(), N/2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", edge_no, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule